// File: doc/BRIEF.md
# Endpoint DMA Enable Control

This block keeps the per-endpoint permission that lets a DMA engine move data for each of 32 USB device endpoints. Software never writes the enable word directly. It writes a one-hot style mask to a set address to grant DMA, or to a clear address to withdraw it. Bits written as 0 leave their endpoint alone, so several agents can change their own endpoints without a read-modify-write sequence.

The DMA engine reports a per-endpoint transfer-active level and a per-endpoint error pulse. A withdrawal that arrives while a transfer is running is held back until that transfer ends. An error withdraws the permission at once. Endpoints 0 and 1 carry control traffic and can never be granted DMA.

A proceed flag is raised by a pulse from the DMA engine and dropped by any write to the clear address. A read-only summary word has one bit per interrupt source register, and each bit is 1 when any bit of that source is 1.

Top module: `ep_dma_enable_regs`

## Requirements
- R1: A bus write to word address 1 (set) with bit n of the data at 1 makes enable bit n equal to 1 after the next clock edge, for n from 2 to 31. A data bit of 0 leaves that endpoint unchanged.
- R2: A bus write to word address 2 (clear) with bit n at 1, for an endpoint whose transfer-active input is 0, makes enable bit n equal to 0 after the next clock edge. A data bit of 0 leaves that endpoint unchanged.
- R3: Enable bits 0 and 1 read 0 at all times, whatever is written to any address.
- R4: Any write to the clear address clears the proceed flag, including a write of all zeros. This holds even when the proceed pulse is high in the same cycle.
- R5: A clear for an enabled endpoint whose transfer-active input is 1 keeps the bit at 1. The bit falls at the first clock edge at which transfer-active is sampled 0. A set for that endpoint before then cancels the pending clear.
- R6: An error pulse on endpoint n makes enable bit n equal to 0 after the next clock edge. The error wins over a set for the same endpoint in the same cycle.
- R7: Reads of the set and clear addresses return 0. Writes to word address 0 (enable status) and word address 3 (summary) change no state.
- R8: Summary bit k is 1 exactly when any bit of the 32-bit slice k of the interrupt source input is 1. Reading word address 3 returns the summary zero-extended. Reading word address 0 returns the enable word.
- R9: After reset all enable bits, all pending clears and the proceed flag are 0.
- R10: A proceed pulse with no clear write in the same cycle sets the proceed flag after the next clock edge. The flag stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address: 0 status, 1 set, 2 clear, 3 summary |
| bus_wdata | input | 32 | Write data, one bit per endpoint |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| xfer_active | input | 32 | Transfer in progress, per endpoint |
| xfer_error | input | 32 | Error detected, per endpoint |
| proceed_set | input | 1 | Pulse that raises the proceed flag |
| int_src | input | 96 | Three 32-bit interrupt source registers, concatenated |
| dma_enable | output | 32 | Effective enable vector |
| dma_proceed | output | 1 | Proceed flag |
| int_summary | output | 3 | One bit per interrupt source register |

## Verification
The cell assertions rely on the bus carrying one address per cycle. Because of that, a set and a clear for the same endpoint never arrive together. They also rely on the transfer-active and error inputs being known values from the DMA engine after reset. The bench drives every input at the falling clock edge and issues one bus access per cycle. Its random transfer-active vectors change freely from cycle to cycle. It keeps error vectors sparse by combining several random words with AND, so that deferred clears get to complete. The collision cases are driven directly: error with set, proceed pulse with clear, and set during a pending clear.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;

  typedef enum logic [1:0] {
    REG_STATUS  = 2'd0,
    REG_SET     = 2'd1,
    REG_CLR     = 2'd2,
    REG_SUMMARY = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic pend;
  } ep_state_t;

  // Next state of one endpoint: error first, then set, then clear, then release.
  function automatic ep_state_t ep_step(ep_state_t cur, logic set_r, logic clr_r,
                                        logic act, logic err);
    ep_state_t nx;
    nx = cur;
    if (err) begin
      nx = '0;
    end else if (set_r) begin
      nx.en   = 1'b1;
      nx.pend = 1'b0;
    end else if (clr_r) begin
      if (act && cur.en) nx.pend = 1'b1;
      else               nx      = '0;
    end else if (cur.pend && !act) begin
      nx = '0;
    end
    return nx;
  endfunction

endpackage

// File: rtl/ep_enable_cell.sv
module ep_enable_cell
  import ep_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic xfer_act,
  input  logic xfer_err,
  output logic en,
  output logic pend
);

  ep_state_t st_q;
  ep_state_t st_d;

  assign st_d = ep_step(st_q, set_req, clr_req, xfer_act, xfer_err);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign en   = st_q.en;
  assign pend = st_q.pend;

  AST_SET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !xfer_err) |=> en); // R1
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !xfer_act && !xfer_err) |=> !en); // R2
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && xfer_act && en && !xfer_err) |=> en); // R5
  AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !xfer_act && !set_req && !xfer_err) |=> !en); // R5
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !en); // R6

endmodule

// File: rtl/ep_enable_bank.sv
module ep_enable_bank #(
  parameter int EP_W   = 32,
  parameter int LOCK_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EP_W-1:0] set_vec,
  input  logic [EP_W-1:0] clr_vec,
  input  logic [EP_W-1:0] act_vec,
  input  logic [EP_W-1:0] err_vec,
  output logic [EP_W-1:0] en_vec
);

  logic [EP_W-1:0] pend_vec;
  logic            unused_lock_in;

  // Control endpoints take no part in DMA; their request bits are dropped here.
  assign unused_lock_in = ^{set_vec[LOCK_W-1:0], clr_vec[LOCK_W-1:0],
                            act_vec[LOCK_W-1:0], err_vec[LOCK_W-1:0],
                            pend_vec[LOCK_W-1:0]};

  for (genvar g = 0; g < EP_W; g++) begin : g_ep
    if (g < LOCK_W) begin : g_locked
      assign en_vec[g]   = 1'b0;
      assign pend_vec[g] = 1'b0;
    end else begin : g_live
      ep_enable_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_vec[g]),
        .clr_req  (clr_vec[g]),
        .xfer_act (act_vec[g]),
        .xfer_err (err_vec[g]),
        .en       (en_vec[g]),
        .pend     (pend_vec[g])
      );
    end
  end

endmodule

// File: rtl/proceed_flag.sv
module proceed_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_evt,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (clr_evt)   flag_q <= 1'b0;
    else if (set_pulse) flag_q <= 1'b1;
  end

  assign flag = flag_q;

  AST_PROCEED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !flag); // R4
  AST_PROCEED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse && !clr_evt) |=> flag); // R10

endmodule

// File: rtl/int_summary.sv
module int_summary #(
  parameter int SRC_N = 3,
  parameter int EP_W  = 32
) (
  input  logic [SRC_N*EP_W-1:0] src,
  output logic [SRC_N-1:0]      any
);

  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    assign any[k] = |src[k*EP_W +: EP_W];
  end

endmodule

// File: rtl/ep_dma_enable_regs.sv
module ep_dma_enable_regs
  import ep_dma_pkg::*;
#(
  parameter int EP_W   = 32,
  parameter int SRC_N  = 3,
  parameter int LOCK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_addr,
  input  logic [EP_W-1:0]       bus_wdata,
  output logic [EP_W-1:0]       bus_rdata,
  input  logic [EP_W-1:0]       xfer_active,
  input  logic [EP_W-1:0]       xfer_error,
  input  logic                  proceed_set,
  input  logic [SRC_N*EP_W-1:0] int_src,
  output logic [EP_W-1:0]       dma_enable,
  output logic                  dma_proceed,
  output logic [SRC_N-1:0]      int_summary
);

  localparam int SUM_PAD = EP_W - SRC_N;

  // Named bus events
  logic            wr_set_evt;
  logic            wr_clr_evt;
  logic [EP_W-1:0] set_vec;
  logic [EP_W-1:0] clr_vec;

  assign wr_set_evt = bus_wr && (bus_addr == REG_SET);
  assign wr_clr_evt = bus_wr && (bus_addr == REG_CLR);
  assign set_vec    = wr_set_evt ? bus_wdata : '0;
  assign clr_vec    = wr_clr_evt ? bus_wdata : '0;

  ep_enable_bank #(.EP_W(EP_W), .LOCK_W(LOCK_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .act_vec (xfer_active),
    .err_vec (xfer_error),
    .en_vec  (dma_enable)
  );

  proceed_flag u_proceed (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (proceed_set),
    .clr_evt   (wr_clr_evt),
    .flag      (dma_proceed)
  );

  int_summary #(.SRC_N(SRC_N), .EP_W(EP_W)) u_summary (
    .src (int_src),
    .any (int_summary)
  );

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_STATUS:  bus_rdata = dma_enable;
      REG_SUMMARY: bus_rdata = {{SUM_PAD{1'b0}}, int_summary};
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: tb/ep_dma_enable_regs_bench.sv
module ep_dma_enable_regs_bench;

  localparam int EP_W  = 32;
  localparam int SRC_N = 3;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  bus_wr;
  logic [1:0]            bus_addr;
  logic [EP_W-1:0]       bus_wdata;
  logic [EP_W-1:0]       bus_rdata;
  logic [EP_W-1:0]       xfer_active;
  logic [EP_W-1:0]       xfer_error;
  logic                  proceed_set;
  logic [SRC_N*EP_W-1:0] int_src;
  logic [EP_W-1:0]       dma_enable;
  logic                  dma_proceed;
  logic [SRC_N-1:0]      int_summary;

  always #5 clk = ~clk;

  ep_dma_enable_regs u_ep_dma_enable_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_active(xfer_active),
    .xfer_error(xfer_error), .proceed_set(proceed_set), .int_src(int_src),
    .dma_enable(dma_enable), .dma_proceed(dma_proceed), .int_summary(int_summary)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] m_en, m_pend;
  logic        m_proc;

  localparam logic [31:0] CTRL_MASK = 32'h0000_0003;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_summary(logic [95:0] s);
    logic [2:0] r = '0;
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < 32; b++)
        if (s[k*32+b]) r[k] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] a, logic [95:0] s);
    if (a == 2'd0) return m_en;
    if (a == 2'd3) return {29'd0, exp_summary(s)};
    return 32'd0;
  endfunction

  // One bus cycle: drive at falling edge, check reads, model the edge, check state.
  task automatic cyc(string tag, logic w, logic [1:0] a, logic [31:0] d,
                     logic [31:0] act, logic [31:0] err, logic ps, logic [95:0] s);
    logic [31:0] sv, cv, n_en, n_pend;
    logic        n_proc;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    xfer_active = act; xfer_error = err; proceed_set = ps; int_src = s;
    #1;
    chk({tag, " R7/R8 rdata"}, bus_rdata, exp_read(a, s));
    chk({tag, " R8 summary"}, {29'd0, int_summary}, {29'd0, exp_summary(s)});
    sv = (w && a == 2'd1) ? d : 32'd0;
    cv = (w && a == 2'd2) ? d : 32'd0;
    n_pend = ~err & ~sv & ((cv & act & m_en) | (~cv & m_pend & act));
    n_en   = ~err & (sv | (m_en & ~cv & ~(m_pend & ~act)) | (cv & act & m_en));
    n_en   = n_en & ~CTRL_MASK;
    n_pend = n_pend & ~CTRL_MASK;
    n_proc = (w && a == 2'd2) ? 1'b0 : (ps ? 1'b1 : m_proc);
    @(negedge clk);
    m_en = n_en; m_pend = n_pend; m_proc = n_proc;
    chk({tag, " enable"}, dma_enable, m_en);
    chk({tag, " R3 ctrl bits"}, dma_enable & CTRL_MASK, 32'd0);
    chk({tag, " proceed"}, {31'd0, dma_proceed}, {31'd0, m_proc});
  endtask

  task automatic idle(string tag, logic [31:0] act);
    cyc(tag, 1'b0, 2'd0, 32'd0, act, 32'd0, 1'b0, 96'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [95:0] s;
    rst_n = 1'b0; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = '1;
    xfer_active = '0; xfer_error = '0; proceed_set = 1'b1; int_src = '0;
    m_en = '0; m_pend = '0; m_proc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset enable", dma_enable, 32'd0);
    chk("R9 reset proceed", {31'd0, dma_proceed}, 32'd0);
    rst_n = 1'b1;

    // R1 and R3: set every bit
    cyc("R1 set all", 1'b1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    chk("R3 after set all", dma_enable, 32'hFFFF_FFFC);
    // R2: clear some idle endpoints, zeros leave others
    cyc("R2 clear idle", 1'b1, 2'd2, 32'h0000_00F0, 0, 0, 0, 0);
    cyc("R2 clear zero", 1'b1, 2'd2, 32'd0, 0, 0, 0, 0);
    // R10 then R4
    cyc("R10 proceed pulse", 1'b0, 2'd0, 0, 0, 0, 1'b1, 0);
    idle("R10 proceed hold", 0);
    cyc("R4 zero clear drops proceed", 1'b1, 2'd2, 32'd0, 0, 0, 0, 0);
    cyc("R10 proceed again", 1'b0, 2'd0, 0, 0, 0, 1'b1, 0);
    cyc("R4 clear beats pulse", 1'b1, 2'd2, 32'd0, 0, 0, 1'b1, 0);
    // R5 deferred clear on endpoint 9
    cyc("R5 clear while active", 1'b1, 2'd2, 32'h0000_0200, 32'h0000_0200, 0, 0, 0);
    chk("R5 held", {31'd0, dma_enable[9]}, 32'd1);
    idle("R5 still active", 32'h0000_0200);
    idle("R5 transfer ends", 32'd0);
    chk("R5 dropped", {31'd0, dma_enable[9]}, 32'd0);
    // R5 set cancels a pending clear on endpoint 10
    cyc("R5 clear ep10 active", 1'b1, 2'd2, 32'h0000_0400, 32'h0000_0400, 0, 0, 0);
    cyc("R5 set cancels", 1'b1, 2'd1, 32'h0000_0400, 32'h0000_0400, 0, 0, 0);
    idle("R5 end after cancel", 32'd0);
    chk("R5 kept", {31'd0, dma_enable[10]}, 32'd1);
    // R6 error alone and error against set
    cyc("R6 error", 1'b0, 2'd0, 0, 32'h0000_0800, 32'h0000_0800, 0, 0);
    cyc("R6 error beats set", 1'b1, 2'd1, 32'h0000_0080, 0, 32'h0000_0080, 0, 0);
    chk("R6 bit7 low", {31'd0, dma_enable[7]}, 32'd0);
    // R7 read-only and write-only addresses
    cyc("R7 write status", 1'b1, 2'd0, 32'h0000_0000, 0, 0, 0, 0);
    cyc("R7 write summary", 1'b1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cyc("R7 read set addr", 1'b0, 2'd1, 0, 0, 0, 0, 0);
    cyc("R7 read clear addr", 1'b0, 2'd2, 0, 0, 0, 0, 0);
    // R8 summary patterns
    cyc("R8 src2 top bit", 1'b0, 2'd3, 0, 0, 0, 0, {1'b1, 95'd0});
    cyc("R8 src0 low bit", 1'b0, 2'd3, 0, 0, 0, 0, 96'd1);
    cyc("R8 src1 mid", 1'b0, 2'd0, 0, 0, 0, 0, {32'd0, 32'h0001_0000, 32'd0});
    // R3 try control bits
    cyc("R3 set ctrl", 1'b1, 2'd1, 32'h0000_0003, 0, 0, 0, 0);

    // Random phase
    void'($urandom(32'd4242));
    for (int i = 0; i < 600; i++) begin
      for (int k = 0; k < 3; k++)
        s[k*32 +: 32] = ($urandom % 3 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
      cyc("RND", 1'($urandom % 2), 2'($urandom % 4), $urandom,
          $urandom & $urandom, $urandom & $urandom & $urandom & $urandom,
          1'($urandom % 4 == 0), s);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule